// File: doc/BRIEF.md
# Two-Descriptor Transmit DMA Engine

This block feeds a transmit FIFO from memory using two buffer descriptors that the CPU loads and hands over. The descriptors are called A and B. Each holds a buffer start address, a byte count and a status byte. The engine serves them in a fixed A, B, A, B order. Before each buffer it waits for the CPU to pass it ownership, and when the buffer is finished it hands ownership back. A register tells software which descriptor the engine will take next. This lets the CPU keep one buffer queued while the other is being sent.

Data moves one byte per memory request. Each byte goes onto a byte stream toward the FIFO. When a buffer carries the end-of-frame flag, one extra marker beat follows its last byte, so a downstream framer knows to append its CRC. Buffers without the flag run on into the same frame. Each buffer can raise a buffer-done interrupt, gated by the buffer itself and by a global enable. A transmitter-empty interrupt warns when nothing is left to send. Both interrupts land in a sticky status register that is cleared by writing 1.

Top module: `txd_dma`

## Requirements
- R1: The CPU port uses word index `cpu_addr`, read combinationally. The map is: 0 control (bit0 channel enable); 1 interrupt enable (bit0 buffer-done, bit1 empty); 2, 3, 4 the address, count and status of A; 5, 6, 7 the same for B; 8 next-descriptor indicator; 9 interrupt status. Everything resets to zero.
- R2: Status bit0 is the ownership flag (1 = engine owns it). While it is set, all CPU writes to that descriptor's three registers are ignored.
- R3: After enable the engine waits only for descriptor A. It then alternates strictly A, B, A, B. An owned descriptor that is not the next one is left untouched. Finishing a buffer clears its ownership flag.
- R4: Register 8 bit0 reads 0 when A is next and 1 when B is next.
- R5: Bytes are fetched one per accepted request, at address start, start+1, and so on, and sent in order as data beats (`tx_eof`=0). A stalled beat, or a stalled request, holds its value until it is accepted.
- R6: With status bit6 set, exactly one marker beat (`tx_eof`=1, data 0) follows the last byte. With bit6 clear, no marker is sent, so the next buffer continues the same frame.
- R7: A descriptor with count 0 is released without fetching any data. It still sends the marker beat if its bit6 is set.
- R8: When a buffer is released, interrupt status bit0 is set only if both its status bit1 and enable bit0 are 1. This happens at most once per buffer.
- R9: When bit0 is set for a buffer whose bit6 is set, interrupt status bit6 is set at the same time.
- R10: Interrupt status bit1 is set while enable bit1 is set, the channel is enabled and waiting, the next descriptor is not owned, and `fifo_empty` is high.
- R11: Interrupt status bits are sticky. Writing 1 to a bit clears it. `irq` is high whenever any status bit is set.
- R12: Clearing the channel enable stops all memory and stream activity. The engine returns to waiting on descriptor A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 4 | CPU register word index |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational) |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| tx_valid | output | 1 | Stream beat valid |
| tx_ready | input | 1 | FIFO accepts the beat |
| tx_data | output | 8 | Stream byte |
| tx_eof | output | 1 | Beat is the end-of-frame marker |
| fifo_empty | input | 1 | Transmit FIFO holds no data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W=16 and CNT_W=4. The narrow address makes a buffer that crosses the 0x00FF to 0x0100 boundary cheap to place, and the bytes returned depend on both address bytes, so a carry missing from the upper byte shows up in the data. The small count width keeps every buffer short. This leaves room for the ownership-skip case, chained frames under backpressure, zero-length descriptors and a mid-buffer disable in a few hundred cycles.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_REQ,
    ST_RSP,
    ST_PUSH,
    ST_MARK,
    ST_REL
  } eng_state_t;

  localparam int unsigned OWN_BIT = 0;
  localparam int unsigned IEN_BIT = 1;
  localparam int unsigned EOF_BIT = 6;

  localparam logic [3:0] RA_CTL   = 4'd0;
  localparam logic [3:0] RA_IE    = 4'd1;
  localparam logic [3:0] RA_DESC0 = 4'd2;
  localparam logic [3:0] RA_NEXT  = 4'd8;
  localparam logic [3:0] RA_ISR   = 4'd9;

endpackage

// File: rtl/txd_desc_bank.sv
module txd_desc_bank
  import txd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [3:0]                 wr_addr,
  input  logic [31:0]                wr_data,
  input  logic                       rel_valid,
  input  logic                       rel_sel,
  output logic [1:0][ADDR_W-1:0]     d_addr,
  output logic [1:0][CNT_W-1:0]      d_cnt,
  output logic [1:0][7:0]            d_sts
);

  for (genvar d = 0; d < 2; d++) begin : g_desc
    localparam logic [3:0] BASE = 4'(RA_DESC0 + 4'(3 * d));
    logic              open_wr;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [7:0]        sts_q, sts_n;

    assign open_wr = wr_en && !sts_q[OWN_BIT];

    always_comb begin
      addr_n = addr_q;
      cnt_n  = cnt_q;
      sts_n  = sts_q;
      if (open_wr && wr_addr == BASE)         addr_n = wr_data[ADDR_W-1:0];
      if (open_wr && wr_addr == BASE + 4'd1)  cnt_n  = wr_data[CNT_W-1:0];
      if (open_wr && wr_addr == BASE + 4'd2)  sts_n  = wr_data[7:0];
      if (rel_valid && rel_sel == 1'(d))      sts_n[OWN_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        cnt_q  <= '0;
        sts_q  <= '0;
      end else begin
        addr_q <= addr_n;
        cnt_q  <= cnt_n;
        sts_q  <= sts_n;
      end
    end

    assign d_addr[d] = addr_q;
    assign d_cnt[d]  = cnt_q;
    assign d_sts[d]  = sts_q;
  end

endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [1:0]             own,
  input  logic [1:0]             eof_flag,
  input  logic [1:0][ADDR_W-1:0] d_addr,
  input  logic [1:0][CNT_W-1:0]  d_cnt,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [ADDR_W-1:0]      mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [7:0]             mem_rsp_data,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic                   tx_eof,
  output logic                   rel_valid,
  output logic                   cur,
  output logic                   waiting
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  eng_state_t        st_q, st_n;
  logic              cur_q, cur_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic [7:0]        byte_q, byte_n;

  always_comb begin
    st_n   = st_q;
    cur_n  = cur_q;
    ptr_n  = ptr_q;
    left_n = left_q;
    byte_n = byte_q;
    if (!en) begin
      st_n  = ST_WAIT;
      cur_n = 1'b0;
    end else begin
      case (st_q)
        ST_WAIT: if (own[cur_q]) begin
          ptr_n  = d_addr[cur_q];
          left_n = d_cnt[cur_q];
          if (d_cnt[cur_q] == '0) st_n = eof_flag[cur_q] ? ST_MARK : ST_REL;
          else                    st_n = ST_REQ;
        end
        ST_REQ:  if (mem_req_ready) st_n = ST_RSP;
        ST_RSP:  if (mem_rsp_valid) begin
          byte_n = mem_rsp_data;
          st_n   = ST_PUSH;
        end
        ST_PUSH: if (tx_ready) begin
          ptr_n  = ptr_q + ADDR_W'(1);
          left_n = left_q - LAST;
          if (left_q == LAST) st_n = eof_flag[cur_q] ? ST_MARK : ST_REL;
          else                st_n = ST_REQ;
        end
        ST_MARK: if (tx_ready) st_n = ST_REL;
        ST_REL: begin
          cur_n = ~cur_q;
          st_n  = ST_WAIT;
        end
        default: st_n = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAIT;
      cur_q  <= 1'b0;
      ptr_q  <= '0;
      left_q <= '0;
      byte_q <= '0;
    end else begin
      st_q   <= st_n;
      cur_q  <= cur_n;
      ptr_q  <= ptr_n;
      left_q <= left_n;
      byte_q <= byte_n;
    end
  end

  assign mem_req_valid = en && (st_q == ST_REQ);
  assign mem_req_addr  = ptr_q;
  assign tx_valid      = en && (st_q == ST_PUSH || st_q == ST_MARK);
  assign tx_eof        = (st_q == ST_MARK);
  assign tx_data       = (st_q == ST_MARK) ? 8'h00 : byte_q;
  assign rel_valid     = en && (st_q == ST_REL);
  assign cur           = cur_q;
  assign waiting       = en && (st_q == ST_WAIT);

endmodule

// File: rtl/txd_irq.sv
module txd_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_set,
  input  logic       eof_set,
  input  logic       empty_set,
  input  logic       clr_we,
  input  logic [7:0] clr_mask,
  output logic [7:0] isr
);

  logic [7:0] isr_q, isr_n;

  always_comb begin
    isr_n = isr_q & ~(clr_we ? clr_mask : 8'h00);
    if (done_set)  isr_n[0] = 1'b1;
    if (empty_set) isr_n[1] = 1'b1;
    if (eof_set)   isr_n[6] = 1'b1;
    isr_n &= 8'h43;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_n;
  end

  assign isr = isr_q;

endmodule

// File: rtl/txd_dma.sv
module txd_dma
  import txd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [3:0]        cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_eof,
  input  logic              fifo_empty,
  output logic              irq
);

  logic                   ctl_en, ctl_en_n;
  logic [1:0]             ie_q, ie_n;
  logic [1:0][ADDR_W-1:0] d_addr;
  logic [1:0][CNT_W-1:0]  d_cnt;
  logic [1:0][7:0]        d_sts;
  logic [1:0]             own, eof_flag;
  logic                   rel_valid, cur, waiting;
  logic                   done_set, eof_set, empty_set;
  logic [7:0]             isr;

  always_comb begin
    ctl_en_n = ctl_en;
    ie_n     = ie_q;
    if (cpu_we && cpu_addr == RA_CTL) ctl_en_n = cpu_wdata[0];
    if (cpu_we && cpu_addr == RA_IE)  ie_n     = cpu_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      ie_q   <= '0;
    end else begin
      ctl_en <= ctl_en_n;
      ie_q   <= ie_n;
    end
  end

  txd_desc_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cpu_we), .wr_addr(cpu_addr), .wr_data(cpu_wdata),
    .rel_valid(rel_valid), .rel_sel(cur),
    .d_addr(d_addr), .d_cnt(d_cnt), .d_sts(d_sts)
  );

  for (genvar d = 0; d < 2; d++) begin : g_flags
    assign own[d]      = d_sts[d][OWN_BIT];
    assign eof_flag[d] = d_sts[d][EOF_BIT];
  end

  txd_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_engine (
    .clk(clk), .rst_n(rst_n), .en(ctl_en),
    .own(own), .eof_flag(eof_flag), .d_addr(d_addr), .d_cnt(d_cnt),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_eof(tx_eof),
    .rel_valid(rel_valid), .cur(cur), .waiting(waiting)
  );

  assign done_set  = rel_valid && ie_q[0] && d_sts[cur][IEN_BIT];
  assign eof_set   = done_set && d_sts[cur][EOF_BIT];
  assign empty_set = ie_q[1] && waiting && !own[cur] && fifo_empty;

  txd_irq i_irq (
    .clk(clk), .rst_n(rst_n),
    .done_set(done_set), .eof_set(eof_set), .empty_set(empty_set),
    .clr_we(cpu_we && cpu_addr == RA_ISR), .clr_mask(cpu_wdata[7:0]),
    .isr(isr)
  );

  assign irq = |isr;

  always_comb begin
    case (cpu_addr)
      RA_CTL:  cpu_rdata = {31'd0, ctl_en};
      RA_IE:   cpu_rdata = {30'd0, ie_q};
      4'd2:    cpu_rdata = 32'(d_addr[0]);
      4'd3:    cpu_rdata = 32'(d_cnt[0]);
      4'd4:    cpu_rdata = {24'd0, d_sts[0]};
      4'd5:    cpu_rdata = 32'(d_addr[1]);
      4'd6:    cpu_rdata = 32'(d_cnt[1]);
      4'd7:    cpu_rdata = {24'd0, d_sts[1]};
      RA_NEXT: cpu_rdata = {31'd0, cur};
      RA_ISR:  cpu_rdata = {24'd0, isr};
      default: cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/txd_dma_chk.sv
module txd_dma_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_en,
  input logic              cpu_we,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_eof,
  input logic              irq
);

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!ctl_en || (tx_valid && $stable(tx_data) && $stable(tx_eof))));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (!ctl_en || (mem_req_valid && $stable(mem_req_addr))));

  // R5
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, mem_req_valid}));

  // R12
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (!tx_valid && !mem_req_valid));

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cpu_we) |=> irq);

endmodule

bind txd_dma txd_dma_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .cpu_we(cpu_we),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_eof(tx_eof), .irq(irq)
);

// File: tb/test_txd_dma.sv
module test_txd_dma;

  localparam int unsigned AW = 16;
  localparam int unsigned CW = 4;

  logic          clk;
  logic          rst_n;
  logic          cpu_we;
  logic [3:0]    cpu_addr;
  logic [31:0]   cpu_wdata;
  logic [31:0]   cpu_rdata;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [7:0]    mem_rsp_data;
  logic          tx_valid;
  logic          tx_ready;
  logic [7:0]    tx_data;
  logic          tx_eof;
  logic          fifo_empty;
  logic          irq;

  int n_run;
  int n_fail;
  logic [8:0] beats [0:255];
  int n_beats;
  logic          got;
  logic [AW-1:0] lat;

  txd_dma #(.ADDR_W(AW), .CNT_W(CW)) i_txd_dma (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_eof(tx_eof), .fifo_empty(fifo_empty), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // memory model and stream logger, both at the falling edge
  initial begin
    got = 1'b0;
    lat = '0;
    n_beats = 0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && tx_valid && tx_ready) begin
        beats[n_beats[7:0]] = {tx_eof, tx_data};
        n_beats++;
      end
      mem_rsp_valid = got;
      mem_rsp_data  = mbyte(lat);
      got = mem_req_valid && mem_req_ready;
      lat = mem_req_addr;
    end
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  // descriptor index 0 = A, 1 = B
  task automatic load(input int idx, input logic [15:0] a, input logic [3:0] c, input logic [7:0] s);
    wr(4'(2 + 3 * idx), 32'(a));
    wr(4'(3 + 3 * idx), 32'(c));
    wr(4'(4 + 3 * idx), 32'(s));
  endtask

  task automatic wait_free(input int idx);
    logic [31:0] v;
    for (int k = 0; k < 500; k++) begin
      rd(4'(4 + 3 * idx), v);
      if (!v[0]) break;
    end
  endtask

  task automatic chk_data(input string req, input int at, input logic [15:0] a);
    check(req, 32'(beats[at[7:0]]), {23'd0, 1'b0, mbyte(a)});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd8, v);  check("R4 reset next", v, 0);
    rd(4'd9, v);  check("R1 reset isr", v, 0);
    rd(4'd4, v);  check("R1 reset status A", v, 0);
    check("R11 reset irq", 32'(irq), 0);
    check("R12 reset tx_valid", 32'(tx_valid), 0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    int b0;
    b0 = n_beats;
    wr(4'd1, 32'h1);
    wr(4'd0, 32'h1);
    load(0, 16'h00FE, 4'd3, 8'h43);
    wait_free(0);
    cycles(3);
    check("R5 beat count", 32'(n_beats - b0), 4);
    chk_data("R5 byte0", b0, 16'h00FE);
    chk_data("R5 byte1", b0 + 1, 16'h00FF);
    chk_data("R5 byte2 carry", b0 + 2, 16'h0100);
    check("R6 marker", 32'(beats[8'(b0 + 3)]), 32'h100);
    rd(4'd4, v);  check("R3 own cleared", v, 32'h42);
    rd(4'd8, v);  check("R4 next is B", v, 1);
    rd(4'd9, v);  check("R8 R9 isr", v, 32'h41);
    check("R11 irq high", 32'(irq), 1);
    wr(4'd9, 32'h41);
    rd(4'd9, v);  check("R11 cleared", v, 0);
    check("R11 irq low", 32'(irq), 0);
  endtask

  task automatic t_alternate;
    logic [31:0] v;
    int b0;
    b0 = n_beats;
    load(0, 16'h0300, 4'd1, 8'h01);
    cycles(40);
    rd(4'd4, v);  check("R3 A skipped while B next", v, 32'h01);
    check("R3 no beats", 32'(n_beats - b0), 0);
    load(1, 16'h0400, 4'd1, 8'h01);
    wait_free(1);
    wait_free(0);
    cycles(3);
    check("R3 two beats", 32'(n_beats - b0), 2);
    chk_data("R3 B first", b0, 16'h0400);
    chk_data("R3 A second", b0 + 1, 16'h0300);
    rd(4'd9, v);  check("R8 no irq without bit1", v, 0);
    rd(4'd8, v);  check("R4 next B again", v, 1);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    int b0;
    b0 = n_beats;
    tx_ready = 1'b0;
    load(1, 16'h0020, 4'd2, 8'h01);
    cycles(20);
    check("R5 stalled valid", 32'(tx_valid), 1);
    check("R5 stalled data", 32'(tx_data), 32'(mbyte(16'h0020)));
    wr(4'd5, 32'h7777);
    rd(4'd5, v);  check("R2 write ignored", v, 32'h0020);
    load(0, 16'h0040, 4'd2, 8'h43);
    tx_ready = 1'b1;
    wait_free(0);
    cycles(3);
    check("R6 chain beats", 32'(n_beats - b0), 5);
    chk_data("R6 b0", b0, 16'h0020);
    chk_data("R6 b1", b0 + 1, 16'h0021);
    chk_data("R6 a0", b0 + 2, 16'h0040);
    chk_data("R6 a1", b0 + 3, 16'h0041);
    check("R6 single marker", 32'(beats[8'(b0 + 4)]), 32'h100);
    rd(4'd9, v);  check("R9 eof isr", v, 32'h41);
    wr(4'd9, 32'hFF);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    int b0;
    b0 = n_beats;
    load(1, 16'h0500, 4'd0, 8'h03);
    wait_free(1);
    cycles(3);
    check("R7 no beat without eof", 32'(n_beats - b0), 0);
    rd(4'd9, v);  check("R8 R9 zero done no eof", v, 32'h01);
    load(0, 16'h0600, 4'd0, 8'h43);
    wait_free(0);
    cycles(3);
    check("R7 marker only", 32'(n_beats - b0), 1);
    check("R7 marker value", 32'(beats[8'(b0)]), 32'h100);
    rd(4'd9, v);  check("R9 zero eof", v, 32'h41);
    wr(4'd9, 32'h41);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    wr(4'd1, 32'h0);
    load(1, 16'h0700, 4'd1, 8'h03);
    wait_free(1);
    cycles(3);
    rd(4'd9, v);  check("R8 global gate", v, 0);
    wr(4'd1, 32'h1);
  endtask

  task automatic t_empty;
    logic [31:0] v;
    wr(4'd1, 32'h2);
    fifo_empty = 1'b0;
    cycles(5);
    rd(4'd9, v);  check("R10 not empty", v, 0);
    fifo_empty = 1'b1;
    cycles(3);
    rd(4'd9, v);  check("R10 empty set", v, 32'h02);
    check("R10 irq", 32'(irq), 1);
    wr(4'd1, 32'h0);
    wr(4'd9, 32'h02);
    rd(4'd9, v);  check("R11 empty cleared", v, 0);
    fifo_empty = 1'b0;
    wr(4'd1, 32'h1);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    load(0, 16'h0800, 4'd1, 8'h01);
    wait_free(0);
    rd(4'd8, v);  check("R4 B next before disable", v, 1);
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h1);
    rd(4'd8, v);  check("R12 back to A", v, 0);
    tx_ready = 1'b0;
    load(0, 16'h0900, 4'd3, 8'h01);
    cycles(10);
    check("R12 busy before off", 32'(tx_valid), 1);
    wr(4'd0, 32'h0);
    cycles(2);
    check("R12 stream stops", 32'(tx_valid), 0);
    check("R12 memory stops", 32'(mem_req_valid), 0);
    rd(4'd8, v);  check("R12 next A after off", v, 0);
    tx_ready = 1'b1;
  endtask

  initial begin
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    cpu_we = 1'b0;
    cpu_addr = '0;
    cpu_wdata = '0;
    mem_req_ready = 1'b1;
    tx_ready = 1'b1;
    fifo_empty = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single();
    t_alternate();
    t_chain();
    t_zero();
    t_gate();
    t_empty();
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule